// File: doc/BRIEF.md
# Fault Classification and Reset-or-Exception Arbiter

This block watches the execute stage of a small 32-bit processor and classifies the faulting conditions that can arise there: an unimplemented opword whose upper nibble marks one of the two reserved opcode lines, a return-from-exception whose frame format field is not a legal value, a hardware breakpoint trigger, and a stop instruction that switches tracing on. For each cycle it picks one outcome: a system reset request carrying a cause code, a single vectored exception request, or nothing.

Two configuration bits decide how the illegal-opcode class and the bad-frame class are handled. With a bit clear, the matching condition produces a reset request. With it set, the reset is withheld and a vectored exception is raised instead. The exception request carries a vector number computed inside the block, the program counter to stack, and a flag telling the sequencer whether the interrupt-mask fields of the status register must be rewritten. Only one request leaves the block per cycle; nothing is queued or chained.

All outputs are registered: a condition present in cycle N produces its request in cycle N+1, lasting exactly that one cycle. Decode, stack writes and the handlers themselves lie outside this block.

Top module: `exc_reset_arbiter`

## Requirements
- R1: An opcode fault exists only when `opValid`, `opUnimpl` and `opWord[15:12]` equal to 4'hA (line A) or 4'hF (line F) are present together; an implemented opword, or an unimplemented one with any other upper nibble, produces neither request.
- R2: With `cfgOpcNoReset` = 0, an opcode fault yields `rstReq` = 1 with `rstCause` = 2'b01 (illegal opcode) and no exception.
- R3: With `cfgOpcNoReset` = 1, an opcode fault yields `excReq` = 1 with `excVector` = 10 for line A or 11 for line F, `excPc` = `pcCur`, `maskUpdate` = 1.
- R4: When `rteExec` is 1, `rteFormat` values 4, 5, 6 and 7 are legal and produce nothing; every other value is a format error, which with `cfgAddrNoReset` = 0 yields `rstReq` = 1 with `rstCause` = 2'b10 (illegal address).
- R5: With `cfgAddrNoReset` = 1, a format error yields `excReq` = 1, `excVector` = 14, `excPc` = `pcCur` (the address of the return instruction itself), `maskUpdate` = 1.
- R6: `bkptTrig` yields `excReq` = 1, `excVector` = 12, `excPc` = `pcCur`, `maskUpdate` = 0 (mask and master-state fields left alone).
- R7: `stopExec` with `stopSrTrace` = 1 while `srTrace` = 0 yields `excReq` = 1, `excVector` = 9, `excPc` = `pcNext`, `maskUpdate` = 1; when `srTrace` is already 1 or `stopSrTrace` is 0, nothing is requested.
- R8: At most one of `rstReq`, `excReq` is 1 in any cycle; simultaneous conditions are ranked illegal-address reset, illegal-opcode reset, format-error exception, opcode exception, breakpoint, trace, and only the highest is issued.
- R9: A request appears exactly one cycle after its condition and lasts one cycle; when no request is issued, `rstCause`, `excVector`, `excPc` and `maskUpdate` are 0; `rstSync` = 1 at a clock edge clears every output in the following cycle regardless of inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstSync | input | 1 | Synchronous system reset, active high |
| opValid | input | 1 | An instruction is in execution this cycle |
| opWord | input | 16 | Opword of that instruction |
| opUnimpl | input | 1 | Decoder reports the opword as unimplemented |
| pcCur | input | 32 | Address of the instruction in execution |
| pcNext | input | 32 | Address of the following instruction |
| rteExec | input | 1 | A return-from-exception is executing |
| rteFormat | input | 4 | Frame format field read by that return |
| bkptTrig | input | 1 | Hardware breakpoint trigger |
| stopExec | input | 1 | A stop instruction is executing |
| stopSrTrace | input | 1 | Trace bit of the status value the stop loads |
| srTrace | input | 1 | Current trace bit of the status register |
| cfgOpcNoReset | input | 1 | 1 turns opcode-fault resets into exceptions |
| cfgAddrNoReset | input | 1 | 1 turns format-error resets into exceptions |
| rstReq | output | 1 | Reset request, one cycle |
| rstCause | output | 2 | Reset cause: 01 illegal opcode, 10 illegal address |
| excReq | output | 1 | Exception request, one cycle |
| excVector | output | 8 | Vector number of the exception |
| excPc | output | 32 | Program counter to stack |
| maskUpdate | output | 1 | 1 when the interrupt-mask fields must be rewritten |

## Verification
A return with a bad frame and an unimplemented reserved-line opword can both be reported in the same cycle, and both can also coincide with a breakpoint and a trace-enabling stop. The bench sweeps every opcode class against all sixteen frame formats, the breakpoint input, four stop/trace states and all four settings of the two configuration bits, one vector per cycle, so every collision occurs. Each result is judged against a ranking computed in the bench: only the top-ranked outcome may appear, with the right cause or vector, stacked PC and mask flag, and all other fields zero.

// File: rtl/excdec_pkg.sv
package excdec_pkg;

  typedef enum logic [2:0] {
    KIND_NONE   = 3'd0,
    KIND_FMT    = 3'd1,
    KIND_LINEA  = 3'd2,
    KIND_LINEF  = 3'd3,
    KIND_DEBUG  = 3'd4,
    KIND_TRACE  = 3'd5
  } excKind_e;

  localparam logic [1:0] CAUSE_NONE    = 2'b00;
  localparam logic [1:0] CAUSE_OPCODE  = 2'b01;
  localparam logic [1:0] CAUSE_ADDRESS = 2'b10;

  typedef struct packed {
    logic       rstLoad;
    logic [1:0] rstCode;
    logic       excLoad;
    excKind_e   kind;
  } strobes_t;

endpackage

// File: rtl/excdec_ctrl.sv
module excdec_ctrl
  import excdec_pkg::*;
#(
  parameter int OP_W  = 16,
  parameter int FMT_W = 4
) (
  input  logic             clk,
  input  logic             rstSync,
  input  logic             opValid,
  input  logic [OP_W-1:0]  opWord,
  input  logic             opUnimpl,
  input  logic             rteExec,
  input  logic [FMT_W-1:0] rteFormat,
  input  logic             bkptTrig,
  input  logic             stopExec,
  input  logic             stopSrTrace,
  input  logic             srTrace,
  input  logic             cfgOpcNoReset,
  input  logic             cfgAddrNoReset,
  output strobes_t         strobes
);

  localparam int NIB_LO = OP_W - 4;
  localparam logic [3:0] LINE_A_NIB = 4'hA;
  localparam logic [3:0] LINE_F_NIB = 4'hF;
  localparam logic [FMT_W-1:0] FMT_LO = FMT_W'(4);
  localparam logic [FMT_W-1:0] FMT_HI = FMT_W'(7);

  logic [3:0] lineNib;
  logic       lineA;
  logic       lineF;
  logic       opcFault;
  logic       fmtLegal;
  logic       fmtFault;
  logic       traceArm;

  // Classification of each faulting source
  always_comb begin
    lineNib  = opWord[OP_W-1:NIB_LO];
    lineA    = opValid && opUnimpl && (lineNib == LINE_A_NIB);
    lineF    = opValid && opUnimpl && (lineNib == LINE_F_NIB);
    opcFault = lineA || lineF;
    fmtLegal = (rteFormat >= FMT_LO) && (rteFormat <= FMT_HI);
    fmtFault = rteExec && !fmtLegal;
    traceArm = stopExec && stopSrTrace && !srTrace;
  end

  // Priority selection: resets, format error, opcode, debug, trace
  always_comb begin
    strobes = '{rstLoad: 1'b0, rstCode: CAUSE_NONE, excLoad: 1'b0, kind: KIND_NONE};
    if (fmtFault && !cfgAddrNoReset) begin
      strobes.rstLoad = 1'b1;
      strobes.rstCode = CAUSE_ADDRESS;
    end else if (opcFault && !cfgOpcNoReset) begin
      strobes.rstLoad = 1'b1;
      strobes.rstCode = CAUSE_OPCODE;
    end else if (fmtFault) begin
      strobes.excLoad = 1'b1;
      strobes.kind    = KIND_FMT;
    end else if (lineA) begin
      strobes.excLoad = 1'b1;
      strobes.kind    = KIND_LINEA;
    end else if (lineF) begin
      strobes.excLoad = 1'b1;
      strobes.kind    = KIND_LINEF;
    end else if (bkptTrig) begin
      strobes.excLoad = 1'b1;
      strobes.kind    = KIND_DEBUG;
    end else if (traceArm) begin
      strobes.excLoad = 1'b1;
      strobes.kind    = KIND_TRACE;
    end
  end

  // R8: control never asks for both a reset and an exception
  p_one_strobe_r8: assert property (@(posedge clk) disable iff (rstSync)
    !(strobes.rstLoad && strobes.excLoad));

  // R1: an implemented opword never raises an opcode-class outcome
  p_impl_quiet_r1: assert property (@(posedge clk) disable iff (rstSync)
    (!opUnimpl && !rteExec) |-> !strobes.rstLoad);

  // R4: a legal frame with no other source stays silent
  p_legal_fmt_r4: assert property (@(posedge clk) disable iff (rstSync)
    (rteExec && fmtLegal && !opValid && !bkptTrig && !stopExec) |->
      (!strobes.rstLoad && !strobes.excLoad));

endmodule

// File: rtl/excdec_dpath.sv
module excdec_dpath
  import excdec_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int VEC_W     = 8,
  parameter int VEC_TRACE = 9,
  parameter int VEC_LINEA = 10,
  parameter int VEC_LINEF = 11,
  parameter int VEC_DEBUG = 12,
  parameter int VEC_FMT   = 14
) (
  input  logic             clk,
  input  logic             rstSync,
  input  strobes_t         strobes,
  input  logic [PC_W-1:0]  pcCur,
  input  logic [PC_W-1:0]  pcNext,
  output logic             rstReq,
  output logic [1:0]       rstCause,
  output logic             excReq,
  output logic [VEC_W-1:0] excVector,
  output logic [PC_W-1:0]  excPc,
  output logic             maskUpdate
);

  logic [VEC_W-1:0] vecNext;
  logic [PC_W-1:0]  pcSel;
  logic             maskNext;

  // Vector, stacked PC and mask flag from the selected kind
  always_comb begin
    vecNext  = '0;
    pcSel    = '0;
    maskNext = 1'b0;
    if (strobes.excLoad) begin
      unique case (strobes.kind)
        KIND_FMT:   begin vecNext = VEC_W'(VEC_FMT);   pcSel = pcCur;  maskNext = 1'b1; end
        KIND_LINEA: begin vecNext = VEC_W'(VEC_LINEA); pcSel = pcCur;  maskNext = 1'b1; end
        KIND_LINEF: begin vecNext = VEC_W'(VEC_LINEF); pcSel = pcCur;  maskNext = 1'b1; end
        KIND_DEBUG: begin vecNext = VEC_W'(VEC_DEBUG); pcSel = pcCur;  maskNext = 1'b0; end
        KIND_TRACE: begin vecNext = VEC_W'(VEC_TRACE); pcSel = pcNext; maskNext = 1'b1; end
        default:    begin vecNext = '0;                pcSel = '0;     maskNext = 1'b0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rstSync) begin
      rstReq     <= 1'b0;
      rstCause   <= CAUSE_NONE;
      excReq     <= 1'b0;
      excVector  <= '0;
      excPc      <= '0;
      maskUpdate <= 1'b0;
    end else begin
      rstReq     <= strobes.rstLoad;
      rstCause   <= strobes.rstLoad ? strobes.rstCode : CAUSE_NONE;
      excReq     <= strobes.excLoad;
      excVector  <= vecNext;
      excPc      <= pcSel;
      maskUpdate <= maskNext;
    end
  end

  // R8: outputs never carry both requests
  p_exclusive_r8: assert property (@(posedge clk) disable iff (rstSync)
    !(rstReq && excReq));

  // R2: a reset request always names a cause
  p_cause_set_r2: assert property (@(posedge clk) disable iff (rstSync)
    rstReq |-> (rstCause != CAUSE_NONE));

  // R6: the debug vector leaves the mask fields untouched
  p_debug_mask_r6: assert property (@(posedge clk) disable iff (rstSync)
    (excReq && excVector == VEC_W'(VEC_DEBUG)) |-> !maskUpdate);

  // R7: the trace vector stacks the address after the stop
  p_trace_pc_r7: assert property (@(posedge clk) disable iff (rstSync)
    (excReq && excVector == VEC_W'(VEC_TRACE)) |-> (excPc == $past(pcNext)));

  // R9: idle cycles carry no vector or PC
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (rstSync)
    !excReq |-> (excVector == '0 && excPc == '0 && !maskUpdate));

endmodule

// File: rtl/exc_reset_arbiter.sv
module exc_reset_arbiter
  import excdec_pkg::*;
#(
  parameter int OP_W      = 16,
  parameter int FMT_W     = 4,
  parameter int PC_W      = 32,
  parameter int VEC_W     = 8,
  parameter int VEC_TRACE = 9,
  parameter int VEC_LINEA = 10,
  parameter int VEC_LINEF = 11,
  parameter int VEC_DEBUG = 12,
  parameter int VEC_FMT   = 14
) (
  input  logic             clk,
  input  logic             rstSync,
  input  logic             opValid,
  input  logic [OP_W-1:0]  opWord,
  input  logic             opUnimpl,
  input  logic [PC_W-1:0]  pcCur,
  input  logic [PC_W-1:0]  pcNext,
  input  logic             rteExec,
  input  logic [FMT_W-1:0] rteFormat,
  input  logic             bkptTrig,
  input  logic             stopExec,
  input  logic             stopSrTrace,
  input  logic             srTrace,
  input  logic             cfgOpcNoReset,
  input  logic             cfgAddrNoReset,
  output logic             rstReq,
  output logic [1:0]       rstCause,
  output logic             excReq,
  output logic [VEC_W-1:0] excVector,
  output logic [PC_W-1:0]  excPc,
  output logic             maskUpdate
);

  strobes_t strobes;

  excdec_ctrl #(
    .OP_W  (OP_W),
    .FMT_W (FMT_W)
  ) u_ctrl (
    .clk            (clk),
    .rstSync        (rstSync),
    .opValid        (opValid),
    .opWord         (opWord),
    .opUnimpl       (opUnimpl),
    .rteExec        (rteExec),
    .rteFormat      (rteFormat),
    .bkptTrig       (bkptTrig),
    .stopExec       (stopExec),
    .stopSrTrace    (stopSrTrace),
    .srTrace        (srTrace),
    .cfgOpcNoReset  (cfgOpcNoReset),
    .cfgAddrNoReset (cfgAddrNoReset),
    .strobes        (strobes)
  );

  excdec_dpath #(
    .PC_W      (PC_W),
    .VEC_W     (VEC_W),
    .VEC_TRACE (VEC_TRACE),
    .VEC_LINEA (VEC_LINEA),
    .VEC_LINEF (VEC_LINEF),
    .VEC_DEBUG (VEC_DEBUG),
    .VEC_FMT   (VEC_FMT)
  ) u_dpath (
    .clk        (clk),
    .rstSync    (rstSync),
    .strobes    (strobes),
    .pcCur      (pcCur),
    .pcNext     (pcNext),
    .rstReq     (rstReq),
    .rstCause   (rstCause),
    .excReq     (excReq),
    .excVector  (excVector),
    .excPc      (excPc),
    .maskUpdate (maskUpdate)
  );

  // R4: an illegal frame with address resets enabled resets next cycle
  p_fmt_reset_r4: assert property (@(posedge clk) disable iff (rstSync)
    (rteExec && !(rteFormat inside {4'd4, 4'd5, 4'd6, 4'd7}) && !cfgAddrNoReset) |=>
      (rstReq && rstCause == CAUSE_ADDRESS));

  // R5: a format-error exception stacks the return instruction's address
  p_fmt_pc_r5: assert property (@(posedge clk) disable iff (rstSync)
    (excReq && excVector == VEC_W'(VEC_FMT)) |-> (excPc == $past(pcCur)));

  // R3: opcode-line exceptions only when opcode resets are disabled
  p_opc_cfg_r3: assert property (@(posedge clk) disable iff (rstSync)
    (excReq && (excVector == VEC_W'(VEC_LINEA) || excVector == VEC_W'(VEC_LINEF))) |->
      $past(cfgOpcNoReset));

endmodule

// File: tb/sim_exc_reset_arbiter.sv
module sim_exc_reset_arbiter;

  logic        clk = 1'b0;
  logic        rstSync;
  logic        opValid;
  logic [15:0] opWord;
  logic        opUnimpl;
  logic [31:0] pcCur;
  logic [31:0] pcNext;
  logic        rteExec;
  logic [3:0]  rteFormat;
  logic        bkptTrig;
  logic        stopExec;
  logic        stopSrTrace;
  logic        srTrace;
  logic        cfgOpcNoReset;
  logic        cfgAddrNoReset;
  logic        rstReq;
  logic [1:0]  rstCause;
  logic        excReq;
  logic [7:0]  excVector;
  logic [31:0] excPc;
  logic        maskUpdate;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  exc_reset_arbiter u0 (
    .clk(clk), .rstSync(rstSync), .opValid(opValid), .opWord(opWord),
    .opUnimpl(opUnimpl), .pcCur(pcCur), .pcNext(pcNext), .rteExec(rteExec),
    .rteFormat(rteFormat), .bkptTrig(bkptTrig), .stopExec(stopExec),
    .stopSrTrace(stopSrTrace), .srTrace(srTrace), .cfgOpcNoReset(cfgOpcNoReset),
    .cfgAddrNoReset(cfgAddrNoReset), .rstReq(rstReq), .rstCause(rstCause),
    .excReq(excReq), .excVector(excVector), .excPc(excPc), .maskUpdate(maskUpdate)
  );

  // expected values for the vector driven in the previous cycle
  logic        eRst, eExc, eMask;
  logic [1:0]  eCause;
  logic [7:0]  eVec;
  logic [31:0] ePc;
  string       eTag;

  task automatic idle_inputs();
    opValid = 0; opWord = '0; opUnimpl = 0; pcCur = '0; pcNext = '0;
    rteExec = 0; rteFormat = '0; bkptTrig = 0; stopExec = 0;
    stopSrTrace = 0; srTrace = 0;
  endtask

  task automatic compute_expect();
    logic lineA, lineF, fmtErr, trc;
    lineA  = opValid && opUnimpl && opWord[15:12] == 4'hA;
    lineF  = opValid && opUnimpl && opWord[15:12] == 4'hF;
    fmtErr = rteExec && (rteFormat < 4 || rteFormat > 7);
    trc    = stopExec && stopSrTrace && !srTrace;
    eRst = 0; eExc = 0; eMask = 0; eCause = 2'b00; eVec = 0; ePc = 0; eTag = "R1";
    if (fmtErr && !cfgAddrNoReset) begin
      eRst = 1; eCause = 2'b10; eTag = "R4";
    end else if ((lineA || lineF) && !cfgOpcNoReset) begin
      eRst = 1; eCause = 2'b01; eTag = "R2";
    end else if (fmtErr) begin
      eExc = 1; eVec = 14; ePc = pcCur; eMask = 1; eTag = "R5";
    end else if (lineA || lineF) begin
      eExc = 1; eVec = lineA ? 8'd10 : 8'd11; ePc = pcCur; eMask = 1; eTag = "R3";
    end else if (bkptTrig) begin
      eExc = 1; eVec = 12; ePc = pcCur; eMask = 0; eTag = "R6";
    end else if (trc) begin
      eExc = 1; eVec = 9; ePc = pcNext; eMask = 1; eTag = "R7";
    end
    if ((fmtErr || lineA || lineF) && (bkptTrig || trc || (fmtErr && (lineA || lineF))))
      eTag = {eTag, "/R8"};
  endtask

  task automatic check_out(input string tag);
    total++;
    if (rstReq !== eRst || rstCause !== eCause || excReq !== eExc ||
        excVector !== eVec || excPc !== ePc || maskUpdate !== eMask) begin
      bad++;
      $display("FAIL %s: got rst=%0b cause=%0d exc=%0b vec=%0d pc=%h mask=%0b exp rst=%0b cause=%0d exc=%0b vec=%0d pc=%h mask=%0b",
               tag, rstReq, rstCause, excReq, excVector, excPc, maskUpdate,
               eRst, eCause, eExc, eVec, ePc, eMask);
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int idx = 0;
    idle_inputs();
    cfgOpcNoReset = 0; cfgAddrNoReset = 0;
    rstSync = 1;
    repeat (3) @(negedge clk);
    // R9: reset state
    eRst = 0; eExc = 0; eMask = 0; eCause = 0; eVec = 0; ePc = 0;
    check_out("R9 reset state");
    rstSync = 0;
    @(negedge clk);
    check_out("R9 idle after reset");

    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int oc = 0; oc < 5; oc++) begin
        for (int fm = 0; fm < 17; fm++) begin
          for (int bk = 0; bk < 2; bk++) begin
            for (int ts = 0; ts < 4; ts++) begin
              cfgOpcNoReset  = cfg[0];
              cfgAddrNoReset = cfg[1];
              pcCur  = 32'h0000_1000 + 32'(idx) * 4;
              pcNext = pcCur + 32'd2;
              opValid  = (oc != 0);
              opUnimpl = (oc != 0) && (oc != 4);
              case (oc)
                1: opWord = 16'hA000 | 16'(idx[11:0]);
                2: opWord = 16'hF000 | 16'(idx[11:0]);
                3: opWord = 16'h4000 | 16'(idx[11:0]);
                4: opWord = 16'hA800 | 16'(idx[10:0]);
                default: opWord = 16'hFFFF;
              endcase
              rteExec   = (fm != 16);
              rteFormat = 4'(fm);
              bkptTrig  = bk[0];
              stopExec    = (ts != 0);
              stopSrTrace = (ts == 1) || (ts == 2);
              srTrace     = (ts == 2);
              compute_expect();
              @(negedge clk);
              check_out(eTag);
              idx++;
            end
          end
        end
      end
    end

    // R9: pulse lasts one cycle when the condition goes away
    idle_inputs();
    cfgOpcNoReset = 1; cfgAddrNoReset = 1;
    bkptTrig = 1; pcCur = 32'h0000_8000;
    compute_expect();
    @(negedge clk);
    check_out("R6 single breakpoint");
    idle_inputs();
    compute_expect();
    @(negedge clk);
    check_out("R9 pulse ends");

    // R9: synchronous reset overrides a pending condition
    rteExec = 1; rteFormat = 4'd0; cfgAddrNoReset = 0;
    rstSync = 1;
    @(negedge clk);
    eRst = 0; eExc = 0; eMask = 0; eCause = 0; eVec = 0; ePc = 0;
    check_out("R9 reset masks fault");
    rstSync = 0;
    compute_expect();
    @(negedge clk);
    check_out("R4 fault after reset release");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule